// File: doc/BRIEF.md
# Clock Gate and Reset Line Register Controller

This block is a small register file on a 32-bit memory-mapped bus. It holds the word that gates the clocks of up to 32 peripherals, the word that holds peripherals in reset, and two stored clock-tree words whose meaning lies outside this block. It drives 32 clock-enable outputs and 32 active-high reset outputs straight from those registers.

Two sample peripheral register banks sit behind a read-data multiplexer in the same address space, so that software sees what a real peripheral would show. A bank whose clock is gated reads as zero, ignores writes and keeps its contents. A bank held in reset ignores writes, reads a fixed fill pattern, and comes out of reset holding its initial values. Bank A, standing for the serial flash controller, reads all ones in reset. Bank B, standing for an Ethernet MAC, reads zero in reset.

Requests enter on a valid/ready channel and each accepted request returns exactly one response on a second valid/ready channel. A request is accepted only when the response slot is empty or is being emptied in the same cycle, so back-pressure on the response side stalls the request side. There is no other buffering.

Top module: `clkrst_regblk`

## Requirements
- R1: After reset, clk_en is 0xFFFFFFFF, periph_rst, clk_sel and clk_div are 0, rsp_valid is 0 and req_ready is 1.
- R2: req_ready equals (not rsp_valid) or rsp_ready. A request accepted at a clock edge gives rsp_valid high after that edge. rsp_rdata stays stable while rsp_valid is high and rsp_ready is low. A write response carries rdata 0.
- R3: The clock-enable word at byte offset 0x00 is fully readable and writable and drives clk_en from the edge that accepts the write. The words at 0x04 and 0x08 are readable and writable and drive clk_sel and clk_div.
- R4: The reset-line word at 0x20 drives periph_rst, where a 1 holds the peripheral in reset. Bits 1, 2, 4, 17 and 20 to 26 are not implemented: they read 0, ignore writes and keep their outputs at 0. The writable mask is 0xF80DFFE9.
- R5: A read of any address that is not 0x00, 0x04, 0x08, 0x20 or 0x40 to 0x5F returns 0. A write to such an address changes no register.
- R6: Bank A occupies 0x40 to 0x4F as four words. Its clock enable is clk_en bit 0 and its reset is periph_rst bit 0. While clocked and out of reset it reads back what was written.
- R7: While clk_en bit 0 is 0 and bank A is out of reset, bank A reads 0 and ignores writes. After the bit is set again, the earlier contents read back unchanged.
- R8: While periph_rst bit 0 is 1, bank A reads 0xFFFFFFFF and ignores writes, even while it is gated. From the edge that clears the bit it holds its initial values. The initial value of word i of bank g is 0xC0DE0000 + 256*g + i.
- R9: Bank B occupies 0x50 to 0x5F. Its clock enable and its reset are bit 6 of clk_en and bit 6 of periph_rst. It behaves like bank A except that it reads 0 while held in reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken this cycle |
| rsp_rdata | output | 32 | Read data, 0 for writes |
| clk_en | output | 32 | Per-peripheral clock enables |
| clk_sel | output | 32 | Stored clock-select word |
| clk_div | output | 32 | Stored clock-divide word |
| periph_rst | output | 32 | Per-peripheral reset, active high |

## Verification
The case that needs care is a response being taken in the same cycle that the next request is accepted. The response slot then empties and refills at one edge. The bench stalls rsp_ready with one read response pending and a second read waiting. It checks that req_ready stays low and the first data holds. It then raises rsp_ready and confirms that req_ready follows at once, and that the next response carries the second read's data and not the first. A second case is a write to the reset-line word followed directly by a bank read. That read must already see the fill pattern, or the initial value after a release.

// File: rtl/clkrst_pkg.sv
package clkrst_pkg;
  localparam int unsigned DATA_W = 32;

  localparam int unsigned OFS_EN  = 'h00;
  localparam int unsigned OFS_SEL = 'h04;
  localparam int unsigned OFS_DIV = 'h08;
  localparam int unsigned OFS_RST = 'h20;

  // Implemented reset-line bits; the others are tied off.
  localparam logic [DATA_W-1:0] RST_LIVE_MASK = 32'hF80D_FFE9;
  localparam logic [DATA_W-1:0] EN_RESET_VAL  = 32'hFFFF_FFFF;

  localparam int unsigned BANK_BASE   = 'h40;
  localparam int unsigned BANK_STRIDE = 'h10;

  typedef enum logic [1:0] {
    BANK_LIVE  = 2'd0,
    BANK_GATED = 2'd1,
    BANK_HELD  = 2'd2
  } bank_state_e;

  // Control bit (gate and reset) that owns bank g.
  function automatic int unsigned bank_ctl_bit(input int unsigned g);
    return (g == 0) ? 0 : 5 + g;
  endfunction

  // Readback pattern of bank g while held in reset.
  function automatic logic [DATA_W-1:0] bank_fill(input int unsigned g);
    return (g == 0) ? {DATA_W{1'b1}} : {DATA_W{1'b0}};
  endfunction

  function automatic logic [DATA_W-1:0] bank_init(input int unsigned g, input int unsigned i);
    return 32'hC0DE_0000 + DATA_W'(g) * 32'd256 + DATA_W'(i);
  endfunction
endpackage

// File: rtl/clkrst_bus_if.sv
module clkrst_bus_if #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [DATA_W-1:0] rd_data,
  output logic              acc_wr
);
  logic accept;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign acc_wr    = accept && req_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? '0 : rd_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/clkrst_ctl_regs.sv
module clkrst_ctl_regs
  import clkrst_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] en_q,
  output logic [DATA_W-1:0] sel_q,
  output logic [DATA_W-1:0] div_q,
  output logic [DATA_W-1:0] rst_q,
  output logic [DATA_W-1:0] rd_data
);
  logic hit_en, hit_sel, hit_div, hit_rst;

  assign hit_en  = (addr == ADDR_W'(OFS_EN));
  assign hit_sel = (addr == ADDR_W'(OFS_SEL));
  assign hit_div = (addr == ADDR_W'(OFS_DIV));
  assign hit_rst = (addr == ADDR_W'(OFS_RST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= EN_RESET_VAL;
      sel_q <= '0;
      div_q <= '0;
      rst_q <= '0;
    end else if (wr_en) begin
      if (hit_en)  en_q  <= wdata;
      if (hit_sel) sel_q <= wdata;
      if (hit_div) div_q <= wdata;
      if (hit_rst) rst_q <= wdata & RST_LIVE_MASK;
    end
  end

  always_comb begin
    rd_data = '0;
    if (hit_en)  rd_data = en_q;
    if (hit_sel) rd_data = sel_q;
    if (hit_div) rd_data = div_q;
    if (hit_rst) rd_data = rst_q;
  end
endmodule

// File: rtl/clkrst_periph_bank.sv
module clkrst_periph_bank
  import clkrst_pkg::*;
#(
  parameter int unsigned REGS  = 4,
  parameter int unsigned IDX_W = 2,
  parameter int unsigned G     = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              hold,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [DATA_W-1:0] FILL = bank_fill(G);

  logic [DATA_W-1:0] mem [REGS];
  bank_state_e       state;

  always_comb begin
    if (hold)      state = BANK_HELD;
    else if (!run) state = BANK_GATED;
    else           state = BANK_LIVE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REGS; i++) mem[i] <= bank_init(G, i);
    end else if (state == BANK_HELD) begin
      for (int i = 0; i < REGS; i++) mem[i] <= bank_init(G, i);
    end else if (state == BANK_LIVE && wr_en) begin
      mem[idx] <= wdata;
    end
  end

  always_comb begin
    unique case (state)
      BANK_HELD:  rd_data = FILL;
      BANK_GATED: rd_data = '0;
      default:    rd_data = mem[idx];
    endcase
  end
endmodule

// File: rtl/clkrst_regblk.sv
module clkrst_regblk
  import clkrst_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned BANK_REGS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic [31:0]       clk_en,
  output logic [31:0]       clk_sel,
  output logic [31:0]       clk_div,
  output logic [31:0]       periph_rst
);
  localparam int unsigned IDX_W = $clog2(BANK_REGS);
  localparam int unsigned SPAN  = BANK_REGS * 4;

  logic              acc_wr;
  logic [DATA_W-1:0] ctl_rd;
  logic [DATA_W-1:0] mux_rd;
  logic [DATA_W-1:0] bank_rd [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_hit;

  clkrst_bus_if #(.DATA_W(DATA_W)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .rd_data   (mux_rd),
    .acc_wr    (acc_wr)
  );

  clkrst_ctl_regs #(.ADDR_W(ADDR_W)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (acc_wr),
    .addr    (req_addr),
    .wdata   (req_wdata),
    .en_q    (clk_en),
    .sel_q   (clk_sel),
    .div_q   (clk_div),
    .rst_q   (periph_rst),
    .rd_data (ctl_rd)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    localparam int unsigned BASE = BANK_BASE + g * BANK_STRIDE;
    localparam int unsigned CB   = bank_ctl_bit(g);

    assign bank_hit[g] = ({1'b0, req_addr} >= (ADDR_W+1)'(BASE)) &&
                         ({1'b0, req_addr} <  (ADDR_W+1)'(BASE + SPAN));

    clkrst_periph_bank #(.REGS(BANK_REGS), .IDX_W(IDX_W), .G(g)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (clk_en[CB]),
      .hold    (periph_rst[CB]),
      .wr_en   (acc_wr && bank_hit[g]),
      .idx     (req_addr[IDX_W+1:2]),
      .wdata   (req_wdata),
      .rd_data (bank_rd[g])
    );
  end

  always_comb begin
    mux_rd = ctl_rd;
    for (int g = 0; g < NUM_BANKS; g++) begin
      if (bank_hit[g]) mux_rd = mux_rd | bank_rd[g];
    end
  end
endmodule

// File: rtl/clkrst_regblk_chk.sv
module clkrst_regblk_chk
  import clkrst_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_rdata,
  input logic [31:0]       clk_en,
  input logic [31:0]       periph_rst
);
  logic acc, rd_a, rd_b, rd_undef;

  assign acc  = req_valid && req_ready;
  assign rd_a = acc && !req_write && req_addr >= ADDR_W'('h40) && req_addr < ADDR_W'('h50);
  assign rd_b = acc && !req_write && req_addr >= ADDR_W'('h50) && req_addr < ADDR_W'('h60);
  assign rd_undef = acc && !req_write &&
                    !(req_addr == ADDR_W'(OFS_EN) || req_addr == ADDR_W'(OFS_SEL) ||
                      req_addr == ADDR_W'(OFS_DIV) || req_addr == ADDR_W'(OFS_RST) ||
                      (req_addr >= ADDR_W'('h40) && req_addr < ADDR_W'('h60)));

  AST_READY_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready); // R2
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata)); // R2
  AST_WR_RSP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_write |=> rsp_valid && rsp_rdata == 32'h0); // R2
  AST_EN_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_write && req_addr == ADDR_W'(OFS_EN) |=> clk_en == $past(req_wdata)); // R3
  AST_RST_MASKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_write && req_addr == ADDR_W'(OFS_RST) |=> periph_rst == ($past(req_wdata) & 32'hF80D_FFE9)); // R4
  AST_RST_DEAD_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_rst & 32'h07F2_0016) == 32'h0); // R4
  AST_UNDEF_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_undef |=> rsp_rdata == 32'h0); // R5
  AST_A_GATED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a && !periph_rst[0] && !clk_en[0] |=> rsp_rdata == 32'h0); // R7
  AST_A_HELD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a && periph_rst[0] |=> rsp_rdata == 32'hFFFF_FFFF); // R8
  AST_B_HELD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_b && periph_rst[6] |=> rsp_rdata == 32'h0); // R9
endmodule

bind clkrst_regblk clkrst_regblk_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .req_wdata  (req_wdata),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_rdata  (rsp_rdata),
  .clk_en     (clk_en),
  .periph_rst (periph_rst)
);

// File: tb/clkrst_regblk_bench.sv
module clkrst_regblk_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic [31:0] clk_en, clk_sel, clk_div, periph_rst;

  int checks = 0;
  int failures = 0;

  localparam logic [31:0] LIVE = 32'hF80D_FFE9;

  logic [31:0] m_en, m_sel, m_div, m_rst;
  logic [31:0] m_bank [2][4];

  always #5 clk = ~clk;

  clkrst_regblk u_clkrst_regblk (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .clk_en(clk_en), .clk_sel(clk_sel), .clk_div(clk_div), .periph_rst(periph_rst)
  );

  function automatic logic [31:0] init_val(int g, int i);
    return 32'hC0DE_0000 + 32'(g) * 32'd256 + 32'(i);
  endfunction

  function automatic int ctl_bit(int g);
    return (g == 0) ? 0 : 6;
  endfunction

  function automatic logic [31:0] exp_read(logic [7:0] a);
    int g, i;
    if (a == 8'h00) return m_en;
    if (a == 8'h04) return m_sel;
    if (a == 8'h08) return m_div;
    if (a == 8'h20) return m_rst;
    if (a >= 8'h40 && a < 8'h60) begin
      g = (a - 8'h40) >> 4;
      i = (a >> 2) & 3;
      if (m_rst[ctl_bit(g)]) return (g == 0) ? 32'hFFFF_FFFF : 32'h0;
      if (!m_en[ctl_bit(g)]) return 32'h0;
      return m_bank[g][i];
    end
    return 32'h0;
  endfunction

  function automatic string tag_of(logic [7:0] a);
    if (a == 8'h00 || a == 8'h04 || a == 8'h08) return "R3";
    if (a == 8'h20) return "R4";
    if (a >= 8'h40 && a < 8'h50) return "R6";
    if (a >= 8'h50 && a < 8'h60) return "R9";
    return "R5";
  endfunction

  task automatic model_reset();
    m_en = 32'hFFFF_FFFF; m_sel = '0; m_div = '0; m_rst = '0;
    for (int g = 0; g < 2; g++)
      for (int i = 0; i < 4; i++) m_bank[g][i] = init_val(g, i);
  endtask

  task automatic model_write(logic [7:0] a, logic [31:0] d);
    int g, i;
    if (a == 8'h00) m_en = d;
    else if (a == 8'h04) m_sel = d;
    else if (a == 8'h08) m_div = d;
    else if (a == 8'h20) m_rst = d & LIVE;
    else if (a >= 8'h40 && a < 8'h60) begin
      g = (a - 8'h40) >> 4;
      i = (a >> 2) & 3;
      if (!m_rst[ctl_bit(g)] && m_en[ctl_bit(g)]) m_bank[g][i] = d;
    end
    for (int b = 0; b < 2; b++)
      if (m_rst[ctl_bit(b)])
        for (int k = 0; k < 4; k++) m_bank[b][k] = init_val(b, k);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(logic w, logic [7:0] a, logic [31:0] d, output logic [31:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    r = rsp_rdata;
    chk("R2 rsp_valid", 32'(rsp_valid), 32'h1);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    logic [31:0] r;
    do_op(1'b1, a, d, r);
    chk("R2 write rdata", r, 32'h0);
    model_write(a, d);
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
    logic [31:0] r;
    do_op(1'b0, a, 32'h0, r);
    chk(tag, r, exp);
  endtask

  task automatic ports_chk(string tag);
    chk({tag, " clk_en"}, clk_en, m_en);
    chk({tag, " clk_sel"}, clk_sel, m_sel);
    chk({tag, " clk_div"}, clk_div, m_div);
    chk({tag, " periph_rst"}, periph_rst, m_rst);
  endtask

  task automatic run_all();
    logic [31:0] r;
    logic [7:0] pool [16] = '{8'h00, 8'h04, 8'h08, 8'h20, 8'h40, 8'h44, 8'h48, 8'h4C,
                              8'h50, 8'h54, 8'h58, 8'h5C, 8'h0C, 8'h24, 8'h3C, 8'h60};
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 clk_en", clk_en, 32'hFFFF_FFFF);
    chk("R1 periph_rst", periph_rst, 32'h0);
    chk("R1 clk_sel", clk_sel, 32'h0);
    chk("R1 clk_div", clk_div, 32'h0);
    chk("R1 rsp_valid", 32'(rsp_valid), 32'h0);
    chk("R1 req_ready", 32'(req_ready), 32'h1);
    rst_n = 1'b1;

    // R6 / R8 initial contents and plain access
    rd_chk("R8 init A2", 8'h48, 32'hC0DE_0002);
    wr(8'h44, 32'h1234_5678);
    rd_chk("R6 readback", 8'h44, 32'h1234_5678);
    wr(8'h04, 32'h0000_00A5);
    wr(8'h08, 32'h5A00_0000);
    ports_chk("R3");

    // R7 gating
    wr(8'h00, 32'hFFFF_FFFE);
    chk("R3 clk_en port", clk_en, 32'hFFFF_FFFE);
    rd_chk("R7 gated read", 8'h44, 32'h0);
    wr(8'h44, 32'h0000_DEAD);
    wr(8'h00, 32'hFFFF_FFFF);
    rd_chk("R7 contents kept", 8'h44, 32'h1234_5678);

    // R8 reset hold, priority over gate, release to init
    wr(8'h20, 32'h0000_0001);
    rd_chk("R8 held read", 8'h40, 32'hFFFF_FFFF);
    wr(8'h40, 32'h0BAD_0BAD);
    wr(8'h00, 32'hFFFF_FFFE);
    rd_chk("R8 held and gated", 8'h40, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h20, 32'h0);
    rd_chk("R8 released init", 8'h44, 32'hC0DE_0001);
    rd_chk("R8 write ignored", 8'h40, 32'hC0DE_0000);

    // R4 mask, R9 bank B
    wr(8'h5C, 32'h7777_7777);
    wr(8'h20, 32'hFFFF_FFFF);
    chk("R4 periph_rst", periph_rst, LIVE);
    rd_chk("R4 readback", 8'h20, LIVE);
    rd_chk("R9 held reads zero", 8'h5C, 32'h0);
    wr(8'h20, 32'h0000_1800);
    chk("R4 bits 11 12", periph_rst, 32'h0000_1800);
    rd_chk("R9 released init", 8'h5C, 32'hC0DE_0103);
    wr(8'h20, 32'h0);

    // R5 undefined offsets
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h0C, 32'h1111_1111);
    rd_chk("R5 undef 0x24", 8'h24, 32'h0);
    rd_chk("R5 undef 0x60", 8'h60, 32'h0);
    ports_chk("R5");

    // R2 back-pressure with overlapping take and accept
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h08;
    @(posedge clk);
    @(negedge clk);
    req_addr = 8'h04;
    chk("R2 stalled ready", 32'(req_ready), 32'h0);
    chk("R2 first data", rsp_rdata, m_div);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R2 held data", rsp_rdata, m_div);
      chk("R2 held valid", 32'(rsp_valid), 32'h1);
    end
    @(negedge clk);
    rsp_ready = 1'b1;
    #1;
    chk("R2 ready follows", 32'(req_ready), 32'h1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 second valid", 32'(rsp_valid), 32'h1);
    chk("R2 second data", rsp_rdata, m_sel);
    @(negedge clk);
    chk("R2 drained", 32'(rsp_valid), 32'h0);

    // random mix against the model
    void'($urandom(32'd2024));
    for (int n = 0; n < 600; n++) begin
      logic [7:0] a;
      logic [31:0] d;
      a = pool[$urandom_range(15, 0)];
      d = $urandom();
      if (a == 8'h00) d = d | 32'h0000_0041;
      if (a == 8'h20 && ($urandom_range(1, 0) == 0)) d = 32'h0;
      if ($urandom_range(1, 0) == 1) begin
        wr(a, d);
        ports_chk("R3 random");
      end else begin
        rd_chk({tag_of(a), " random read"}, a, exp_read(a));
      end
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R2 watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule